// File: doc/BRIEF.md
# Core Clock Tree Enable Divider

This block turns one fast clock into three related clock-enable strobes: a processor-core strobe, a bus strobe and a peripheral strobe. Each strobe is high for one clock cycle and repeats at a rate that a configuration word selects. The core and bus dividers count source ticks directly. The peripheral divider counts bus strobes, so its period is the product of the bus and peripheral divisors. The strobes stay in the clock domain of `clk`; the block makes no new clocks.

Two tick qualifiers feed the block: `pll_tick` marks cycles that carry a PLL-rate source edge, and `xtal_tick` marks cycles that carry a crystal-rate edge. A bypass field in the configuration word picks which of them the dividers count. Tie `pll_tick` high to run the dividers at the full `clk` rate. A new configuration word is taken only at a cycle where the core and peripheral strobes fire together, so every strobe gap is a whole old period or a whole new period. The block also decodes the PLL feedback fields of the same word into a combinational multiply/divide ratio pair, which lets software or a checker see the PLL setting. Every pin is a plain control or status signal. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ckd_core_tree`

## Requirements
- R1: The core divisor is field `cfg_word[27:25]`. Codes 0,1,2,3,4 give divide-by 1,2,4,8,16, and codes 5,6,7 give divide-by 1. `core_stb` is high once in every N counted source ticks.
- R2: The bus divisor is field `cfg_word[22:20]`. Codes 0..7 give divide-by 1,2,4,5,6,8,16,32 in that order. `bus_stb` is high once in every N counted source ticks.
- R3: The peripheral divisor is field `cfg_word[19:18]`. Codes 0..3 give divide-by 1,2,4,8. It counts bus strobes, so the `per_stb` period is the bus divisor times the peripheral divisor, counted in source ticks.
- R4: `per_stb` is high only in a cycle in which `bus_stb` is also high.
- R5: Bit `cfg_word[23]` is the not-bypass flag. When it is 1 the dividers count cycles with `pll_tick` high. When it is 0 they count cycles with `xtal_tick` high, and `pll_tick` has no effect.
- R6: `ratio_mul` equals (`cfg_word[15:11]`+1)×(`cfg_word[10:5]`+1), and `ratio_div` equals (`cfg_word[4:0]`+1)×2^`cfg_word[17:16]`. Both are combinational and follow `cfg_word` in the same cycle.
- R7: A change of the divisor fields or of the bypass flag takes effect only at a cycle where the core and peripheral strobes fire together. All counts restart from that cycle.
- R8: While the synchronous active-high `rst` is high, all strobes are low and all counters clear. The first strobe of a divider with divisor N appears in the cycle after the Nth counted source tick after reset.
- R9: A strobe is raised only in the cycle after a clock edge at which the selected source tick was high. Each strobe lasts one cycle per counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all strobes are in this domain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word: divisor codes, not-bypass flag, PLL fields |
| pll_tick | input | 1 | High in cycles carrying a PLL-rate source edge |
| xtal_tick | input | 1 | High in cycles carrying a crystal-rate source edge |
| core_stb | output | 1 | Processor-core clock-enable strobe |
| bus_stb | output | 1 | Bus clock-enable strobe |
| per_stb | output | 1 | Peripheral clock-enable strobe, a subset of bus strobes |
| ratio_mul | output | 12 | PLL multiply factor decoded from cfg_word |
| ratio_div | output | 9 | PLL divide factor decoded from cfg_word |

## Verification
Two things can fall in the same cycle. A configuration update meets the strobe boundary that releases it, and at that same edge the bus and peripheral strobes fire together with the core strobe under the old divisors. The bench provokes this by changing `cfg_word` off-boundary, both to faster and to slower settings and across a bypass switch. An arithmetic reference counts selected ticks from the last common boundary and checks every cycle that the old-period strobe at the boundary is still produced and that the new periods start from that edge. Over every divisor combination it also checks that each peripheral strobe coincides with a bus strobe.

// File: rtl/ckd_pkg.sv
package ckd_pkg;
  localparam int CFG_W    = 32;
  localparam int DIV_W    = 6;
  localparam int CORE_LSB = 25;
  localparam int NBYP_BIT = 23;
  localparam int BUS_LSB  = 20;
  localparam int PER_LSB  = 18;
  localparam int PS_LSB   = 16;
  localparam int X1_LSB   = 11;
  localparam int X2_LSB   = 5;
  localparam int IPD_LSB  = 0;
  localparam int X1_W     = 5;
  localparam int X2_W     = 6;
  localparam int IPD_W    = 5;
  localparam int PS_W     = 2;
  localparam int MUL_W    = X1_W + X2_W + 1;
  localparam int RDIV_W   = IPD_W + 1 + (2**PS_W - 1);

  typedef struct packed {
    logic       nbyp;
    logic [2:0] core;
    logic [2:0] bus;
    logic [1:0] per;
  } sel_t;

  function automatic sel_t pick_sel(input logic [CFG_W-1:0] w);
    sel_t s;
    s.nbyp = w[NBYP_BIT];
    s.core = w[CORE_LSB +: 3];
    s.bus  = w[BUS_LSB +: 3];
    s.per  = w[PER_LSB +: 2];
    return s;
  endfunction

  function automatic logic [DIV_W-1:0] core_div(input logic [2:0] c);
    case (c)
      3'd1:    return DIV_W'(2);
      3'd2:    return DIV_W'(4);
      3'd3:    return DIV_W'(8);
      3'd4:    return DIV_W'(16);
      default: return DIV_W'(1);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] bus_div(input logic [2:0] c);
    case (c)
      3'd0:    return DIV_W'(1);
      3'd1:    return DIV_W'(2);
      3'd2:    return DIV_W'(4);
      3'd3:    return DIV_W'(5);
      3'd4:    return DIV_W'(6);
      3'd5:    return DIV_W'(8);
      3'd6:    return DIV_W'(16);
      default: return DIV_W'(32);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] per_div(input logic [1:0] c);
    return DIV_W'(1) << c;
  endfunction
endpackage

// File: rtl/ckd_tickdiv.sv
module ckd_tickdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);
  logic [DIV_W-1:0] cnt;

  always_comb fire = adv && (cnt == (div - 1'b1));

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ckd_ratio.sv
module ckd_ratio
  import ckd_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [MUL_W-1:0]  ratio_mul,
  output logic [RDIV_W-1:0] ratio_div
);
  logic [MUL_W-1:0]  f1, f2;
  logic [RDIV_W-1:0] dv;

  always_comb begin
    f1        = MUL_W'(cfg_word[X1_LSB +: X1_W]) + 1'b1;
    f2        = MUL_W'(cfg_word[X2_LSB +: X2_W]) + 1'b1;
    dv        = RDIV_W'(cfg_word[IPD_LSB +: IPD_W]) + 1'b1;
    ratio_mul = f1 * f2;
    ratio_div = dv << cfg_word[PS_LSB +: PS_W];
  end
endmodule

// File: rtl/ckd_core_tree.sv
module ckd_core_tree
  import ckd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              pll_tick,
  input  logic              xtal_tick,
  output logic              core_stb,
  output logic              bus_stb,
  output logic              per_stb,
  output logic [MUL_W-1:0]  ratio_mul,
  output logic [RDIV_W-1:0] ratio_div
);
  sel_t act_sel;
  logic src_tick, core_fire, bus_fire, per_fire, boundary;

  always_comb begin
    src_tick = act_sel.nbyp ? pll_tick : xtal_tick;
    boundary = core_fire && per_fire;
  end

  ckd_tickdiv #(.DIV_W(DIV_W)) u_core (
    .clk(clk), .rst(rst), .adv(src_tick),
    .div(core_div(act_sel.core)), .fire(core_fire));

  ckd_tickdiv #(.DIV_W(DIV_W)) u_bus (
    .clk(clk), .rst(rst), .adv(src_tick),
    .div(bus_div(act_sel.bus)), .fire(bus_fire));

  ckd_tickdiv #(.DIV_W(DIV_W)) u_per (
    .clk(clk), .rst(rst), .adv(bus_fire),
    .div(per_div(act_sel.per)), .fire(per_fire));

  always_ff @(posedge clk) begin
    if (rst || boundary) act_sel <= pick_sel(cfg_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_stb <= 1'b0;
      bus_stb  <= 1'b0;
      per_stb  <= 1'b0;
    end else begin
      core_stb <= core_fire;
      bus_stb  <= bus_fire;
      per_stb  <= per_fire;
    end
  end

  ckd_ratio u_ratio (
    .cfg_word(cfg_word), .ratio_mul(ratio_mul), .ratio_div(ratio_div));
endmodule

// File: rtl/ckd_checker.sv
module ckd_checker (
  input logic       clk,
  input logic       rst,
  input logic       pll_tick,
  input logic       xtal_tick,
  input logic       core_stb,
  input logic       bus_stb,
  input logic       per_stb,
  input logic [8:0] act_sel
);
  // act_sel layout: [8] not-bypass, [7:5] core code, [4:2] bus code, [1:0] per code

  p_per_with_bus_r4: assert property (@(posedge clk) disable iff (rst)
    per_stb |-> bus_stb);

  p_idle_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
    (!pll_tick && !xtal_tick) |=> (!core_stb && !bus_stb && !per_stb));

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(rst) |-> (!core_stb && !bus_stb && !per_stb));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (act_sel != $past(act_sel))) |-> (core_stb && per_stb));

  p_div1_every_r1: assert property (@(posedge clk) disable iff (rst)
    (act_sel[8] && pll_tick && (act_sel[7:5] == 3'd0 || act_sel[7:5] >= 3'd5))
      |=> core_stb);
endmodule

bind ckd_core_tree ckd_checker u_chk (
  .clk(clk), .rst(rst), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
  .core_stb(core_stb), .bus_stb(bus_stb), .per_stb(per_stb),
  .act_sel(act_sel));

// File: tb/sim_ckd_core_tree.sv
`timescale 1ns/1ps
module sim_ckd_core_tree;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        pll_tick = 1'b1;
  logic        xtal_tick = 1'b0;
  logic        core_stb, bus_stb, per_stb;
  logic [11:0] ratio_mul;
  logic [8:0]  ratio_div;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ckd_core_tree u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .pll_tick(pll_tick),
    .xtal_tick(xtal_tick), .core_stb(core_stb), .bus_stb(bus_stb),
    .per_stb(per_stb), .ratio_mul(ratio_mul), .ratio_div(ratio_div));

  function automatic int tb_core(input int c);
    int t[8] = '{1, 2, 4, 8, 16, 1, 1, 1};
    return t[c];
  endfunction
  function automatic int tb_bus(input int c);
    int t[8] = '{1, 2, 4, 5, 6, 8, 16, 32};
    return t[c];
  endfunction
  function automatic int tb_per(input int c);
    int t[4] = '{1, 2, 4, 8};
    return t[c];
  endfunction

  // Reference: counts selected ticks since the last common boundary
  int   t_cnt, nc, nb, np;
  logic m_nbyp;
  logic exp_c = 0, exp_b = 0, exp_p = 0;

  task automatic load_model();
    nc     = tb_core(int'(cfg_word[27:25]));
    nb     = tb_bus(int'(cfg_word[22:20]));
    np     = tb_per(int'(cfg_word[19:18]));
    m_nbyp = cfg_word[23];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      t_cnt = 0; exp_c = 0; exp_b = 0; exp_p = 0;
      load_model();
    end else begin
      exp_c = 0; exp_b = 0; exp_p = 0;
      if (m_nbyp ? pll_tick : xtal_tick) begin
        t_cnt = t_cnt + 1;
        exp_c = (t_cnt % nc) == 0;
        exp_b = (t_cnt % nb) == 0;
        exp_p = (t_cnt % (nb * np)) == 0;
        if (exp_c && exp_p) begin
          t_cnt = 0;
          load_model();
        end
      end
    end
  end

  // Per-segment mismatch monitor
  int   cyc = 0;
  int   mis_c, mis_b, mis_p, mis_sub;
  int   first_cyc;
  logic first_act, first_exp;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (core_stb !== exp_c) begin
      if (mis_c == 0) begin first_cyc = cyc; first_act = core_stb; first_exp = exp_c; end
      mis_c++;
    end
    if (bus_stb !== exp_b) mis_b++;
    if (per_stb !== exp_p) mis_p++;
    if (per_stb && !bus_stb) mis_sub++;
  end

  task automatic seg_start();
    mis_c = 0; mis_b = 0; mis_p = 0; mis_sub = 0; first_cyc = -1;
  endtask

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cfg %h, first core miss cycle %0d got %b want %b)",
               tag, act, expv, cfg_word, first_cyc, first_act, first_exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [31:0] w);
    rst = 1'b1; cfg_word = w;
    run(2);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R8: reset state
    cfg_word = {4'b0, 3'd2, 1'b0, 1'b1, 3'd0, 2'd0, 18'd0};
    run(2);
    chk("R8 core_stb low in reset", core_stb, 0);
    chk("R8 bus_stb low in reset", bus_stb, 0);
    chk("R8 per_stb low in reset", per_stb, 0);

    // R1 R2 R3 R4 R8: sweep of every divisor combination, PLL source every cycle
    pll_tick = 1'b1; xtal_tick = 1'b0;
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 4; p++) begin
          seg_start();
          do_reset({4'b0, 3'(c), 1'b0, 1'b1, 3'(b), 2'(p), 18'd0});
          run(262);
          chk("R1 core strobe mismatches", mis_c, 0);
          chk("R2 bus strobe mismatches", mis_b, 0);
          chk("R3 per strobe mismatches", mis_p, 0);
          chk("R4 per without bus", mis_sub, 0);
        end

    // R9: sparse ticks, divide-by-1 everywhere
    seg_start();
    do_reset({4'b0, 3'd0, 1'b0, 1'b1, 3'd0, 2'd0, 18'd0});
    for (int i = 0; i < 90; i++) begin
      pll_tick = (i % 3) != 1; xtal_tick = (i % 5) == 0;
      @(negedge clk);
    end
    chk("R9 core strobe with gaps", mis_c, 0);
    chk("R9 bus strobe with gaps", mis_b, 0);

    // R5: bypass selects crystal ticks, PLL ticks ignored
    seg_start();
    pll_tick = 1'b1; xtal_tick = 1'b0;
    do_reset({4'b0, 3'd1, 1'b0, 1'b0, 3'd1, 2'd1, 18'd0});
    for (int i = 0; i < 160; i++) begin
      xtal_tick = (i % 4) == 3; pll_tick = (i % 2) == 0;
      @(negedge clk);
    end
    chk("R5 core strobe on crystal ticks", mis_c, 0);
    chk("R5 bus strobe on crystal ticks", mis_b, 0);
    chk("R5 per strobe on crystal ticks", mis_p, 0);

    // R7: off-boundary reconfiguration, slow to fast, fast to slow, bypass switch
    seg_start();
    pll_tick = 1'b1; xtal_tick = 1'b0;
    do_reset({4'b0, 3'd4, 1'b0, 1'b1, 3'd3, 2'd1, 18'd0});
    run(37);
    cfg_word = {4'b0, 3'd1, 1'b0, 1'b1, 3'd0, 2'd2, 18'd0};
    run(61);
    cfg_word = {4'b0, 3'd3, 1'b0, 1'b1, 3'd4, 2'd3, 18'd0};
    run(5);
    cfg_word = {4'b0, 3'd2, 1'b0, 1'b0, 3'd2, 2'd0, 18'd0};
    for (int i = 0; i < 420; i++) begin
      xtal_tick = (i % 2) == 0;
      @(negedge clk);
    end
    chk("R7 core strobe across reconfiguration", mis_c, 0);
    chk("R7 bus strobe across reconfiguration", mis_b, 0);
    chk("R7 per strobe across reconfiguration", mis_p, 0);

    // R6: ratio decode sweep
    for (int a = 0; a < 32; a += 5)
      for (int b = 0; b < 64; b += 9)
        for (int d = 0; d < 32; d += 7)
          for (int s = 0; s < 4; s++) begin
            cfg_word = {4'b0, 3'd0, 1'b0, 1'b1, 3'd0, 2'd0, 2'(s), 5'(a), 6'(b), 5'(d)};
            #1;
            chk("R6 ratio_mul", int'(ratio_mul), (a + 1) * (b + 1));
            chk("R6 ratio_div", int'(ratio_div), (d + 1) * (1 << s));
          end
    cfg_word = {14'd0, 2'd3, 5'd31, 6'd63, 5'd31};
    #1;
    chk("R6 ratio_mul maximum", int'(ratio_mul), 2048);
    chk("R6 ratio_div maximum", int'(ratio_div), 256);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule